// File: doc/BRIEF.md
# Banked GPIO Interrupt Detector

This unit turns already-synchronised GPIO pin inputs into a single interrupt request. The pins are grouped in banks. Each pin has its own trigger configuration: level or edge, the active polarity, and an option to fire on both edges. When a pin's condition is met, a sticky per-pin status bit is set. Software clears that bit by writing 1 to it.

Every pin also has a mask bit. Software masks a pin through a dedicated "mask-set" register and unmasks it through a dedicated "mask-clear" register, and it can read the resulting mask back. The unmasked pending bits of all pins in all banks are OR-ed together and registered to drive one interrupt line towards a downstream interrupt controller.

Software reaches the unit through a simple single-cycle register port. A write is taken on the clock edge where `bus_wr` is high. Read data is a combinational function of `bus_addr`.

Top module: `gpio_irq_unit`

## Requirements
- R1: While reset (`rst_n` low, sampled synchronously) is applied, every mask bit reads 1, and status, trigger, polarity and both-edge bits read 0. `irq_o` is 0.
- R2: Writing to the mask-clear register (word offset 0x10 within a bank) clears the mask bits written as 1 and leaves bits written as 0 unchanged. The mask readback register (word 0x0C) shows 1 for a masked pin.
- R3: Writing to the mask-set register (word 0x14) sets the mask bits written as 1 and leaves bits written as 0 unchanged. Writing all ones masks every pin of that bank.
- R4: A pin whose trigger bit (word 0x1C) is 0 uses level detection, active high when its polarity bit (word 0x20) is 1 and active low when it is 0. Status is set again on every cycle the active level persists, so a clear while the level remains active does not stick.
- R5: A pin whose trigger bit is 1 and whose both-edge bit (word 0x24) is 0 sets status on a rising edge (polarity 1) or a falling edge (polarity 0). An edge is a change between the sample of the previous cycle and the current one.
- R6: A pin whose trigger bit and both-edge bit are both 1 sets status on either edge, whatever its polarity bit holds.
- R7: Writing to the status register (word 0x18) clears the bits written as 1 and leaves bits written as 0 unchanged.
- R8: When a detection and a clear of the same status bit fall in the same cycle, the status bit stays set.
- R9: `irq_o` is 1 exactly when, on the previous clock edge, at least one pin in any bank had its status bit set while unmasked.
- R10: Bank b occupies addresses 0x200 + 0x40·b + word. Pin b·PINS_PER_BANK + i maps to bit i of that bank's registers. The mask-clear and mask-set registers, unused words and addresses outside the banks read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_BANKS*PINS_PER_BANK | Synchronised pin levels |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Register read data for `bus_addr` |
| irq_o | output | 1 | Registered OR of all unmasked pending bits |

## Verification
The collision that matters is a detection and a software clear on the same status bit in the same cycle. For edge mode the new event must survive the clear. For level mode the bit must be set again after the clear. The bench provokes this directly by raising a configured pin in the very cycle it writes ones to the status register. The randomized phase then repeats the collision thousands of times by mixing random pin toggles with random status writes. Every status readback and every cycle of `irq_o` is judged against a bench model that applies the clear first and then ORs in the detection.

// File: rtl/gpio_irq_pkg.sv
// Shared definitions for the banked GPIO interrupt detector.
// Assumes banks start at byte address 0x200 with a 0x40 stride.
package gpio_irq_pkg;

    // Register selected by a decoded bus address.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MASK_RD,
        SEL_UNMASK,
        SEL_MASKSET,
        SEL_STATUS,
        SEL_TRIG,
        SEL_POL,
        SEL_BOTH
    } reg_sel_e;

    // Word offsets inside one bank window.
    localparam logic [5:0] WORD_MASK_RD = 6'h0C;
    localparam logic [5:0] WORD_UNMASK  = 6'h10;
    localparam logic [5:0] WORD_MASKSET = 6'h14;
    localparam logic [5:0] WORD_STATUS  = 6'h18;
    localparam logic [5:0] WORD_TRIG    = 6'h1C;
    localparam logic [5:0] WORD_POL     = 6'h20;
    localparam logic [5:0] WORD_BOTH    = 6'h24;

    // Bank window index of bank 0 (0x200 >> 6).
    localparam int BANK_BASE_IDX = 8;

endpackage

// File: rtl/gpio_irq_detect.sv
// Per-pin trigger detector for one bank.
// Compares each pin with its sample from the previous cycle and applies
// the pin's trigger mode. The history register has no reset: it simply
// tracks the pin, so no false edge is seen when reset is released.
module gpio_irq_detect #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic [WIDTH-1:0] pin,
    input  logic [WIDTH-1:0] trig,
    input  logic [WIDTH-1:0] pol,
    input  logic [WIDTH-1:0] both,
    output logic [WIDTH-1:0] hit
);

    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] rise;
    logic [WIDTH-1:0] fall;
    logic [WIDTH-1:0] lvl_hit;
    logic [WIDTH-1:0] edge_hit;

    // Keep last cycle's pin sample for edge detection.
    always_ff @(posedge clk) begin
        prev_q <= pin;
    end

    // Combine the level and edge conditions per pin.
    always_comb begin
        rise     = pin & ~prev_q;
        fall     = ~pin & prev_q;
        lvl_hit  = ~(pin ^ pol);
        edge_hit = (both & (rise | fall)) |
                   (~both & ((pol & rise) | (~pol & fall)));
        hit      = (trig & edge_hit) | (~trig & lvl_hit);
    end

endmodule

// File: rtl/gpio_irq_bank.sv
// Register set and sticky status of one GPIO bank.
// Assumes at most one write strobe is high per cycle (one bus address).
// A detection in the same cycle as a clear keeps the status bit set.
module gpio_irq_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin,
    input  logic             wr_unmask,
    input  logic             wr_maskset,
    input  logic             wr_status,
    input  logic             wr_trig,
    input  logic             wr_pol,
    input  logic             wr_both,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] mask_q,
    output logic [WIDTH-1:0] stat_q,
    output logic [WIDTH-1:0] trig_q,
    output logic [WIDTH-1:0] pol_q,
    output logic [WIDTH-1:0] both_q,
    output logic [WIDTH-1:0] hit
);

    logic [WIDTH-1:0] clr_bits;

    gpio_irq_detect #(.WIDTH(WIDTH)) det_i (
        .clk  (clk),
        .pin  (pin),
        .trig (trig_q),
        .pol  (pol_q),
        .both (both_q),
        .hit  (hit)
    );

    // Bits software asks to clear this cycle.
    always_comb begin
        clr_bits = wr_status ? wdata : '0;
    end

    // Mask register with separate set and clear write ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (wr_unmask) begin
            mask_q <= mask_q & ~wdata;
        end else if (wr_maskset) begin
            mask_q <= mask_q | wdata;
        end
    end

    // Sticky status: clear first, then a new detection wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_bits) | hit;
        end
    end

    // Trigger configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q <= '0;
            pol_q  <= '0;
            both_q <= '0;
        end else begin
            if (wr_trig) trig_q <= wdata;
            if (wr_pol)  pol_q  <= wdata;
            if (wr_both) both_q <= wdata;
        end
    end

endmodule

// File: rtl/gpio_irq_decode.sv
// Address decoder for the banked register windows.
// Gives the bank index and the register selected. Anything outside the
// populated banks or on an unused word decodes to SEL_NONE.
module gpio_irq_decode
    import gpio_irq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ADDR_W    = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [((NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1)-1:0] bank,
    output reg_sel_e          sel
);

    localparam int HI_W  = ADDR_W - 6;
    localparam int BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic [HI_W-1:0] hi;
    logic [HI_W-1:0] idx;
    logic [5:0]      word;
    logic            in_range;

    // Split the address into window index and word offset.
    always_comb begin
        hi       = addr[ADDR_W-1:6];
        word     = addr[5:0];
        idx      = hi - HI_W'(BANK_BASE_IDX);
        in_range = (int'(hi) >= BANK_BASE_IDX) && (int'(idx) < NUM_BANKS);
        bank     = idx[BIDX_W-1:0];
    end

    // Map the word offset onto a register.
    always_comb begin
        sel = SEL_NONE;
        if (in_range) begin
            case (word)
                WORD_MASK_RD: sel = SEL_MASK_RD;
                WORD_UNMASK:  sel = SEL_UNMASK;
                WORD_MASKSET: sel = SEL_MASKSET;
                WORD_STATUS:  sel = SEL_STATUS;
                WORD_TRIG:    sel = SEL_TRIG;
                WORD_POL:     sel = SEL_POL;
                WORD_BOTH:    sel = SEL_BOTH;
                default:      sel = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_unit.sv
// Banked GPIO interrupt detector: top level.
// Decodes the register port, replicates one bank per NUM_BANKS and ORs
// all unmasked status bits into one registered interrupt.
// Assumes pin_i is already synchronised and PINS_PER_BANK <= DATA_W.
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NUM_BANKS     = 4,
    parameter int PINS_PER_BANK = 32,
    parameter int ADDR_W        = 12,
    parameter int DATA_W        = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_BANKS*PINS_PER_BANK-1:0] pin_i,
    input  logic                               bus_wr,
    input  logic [ADDR_W-1:0]                  bus_addr,
    input  logic [DATA_W-1:0]                  bus_wdata,
    output logic [DATA_W-1:0]                  bus_rdata,
    output logic                               irq_o
);

    localparam int PW     = PINS_PER_BANK;
    localparam int NP     = NUM_BANKS * PINS_PER_BANK;
    localparam int BIDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    logic [BIDX_W-1:0] dec_bank;
    reg_sel_e          dec_sel;

    logic [PW-1:0] mask_a [NUM_BANKS];
    logic [PW-1:0] stat_a [NUM_BANKS];
    logic [PW-1:0] trig_a [NUM_BANKS];
    logic [PW-1:0] pol_a  [NUM_BANKS];
    logic [PW-1:0] both_a [NUM_BANKS];

    logic [NP-1:0] stat_all;
    logic [NP-1:0] mask_all;
    logic [NP-1:0] hit_all;
    logic          pend_any;
    logic          irq_q;

    gpio_irq_decode #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) dec_i (
        .addr (bus_addr),
        .bank (dec_bank),
        .sel  (dec_sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit_bank_sel;

        // Strobe for this bank when the decoded index matches.
        assign hit_bank_sel = bus_wr && (int'(dec_bank) == b);

        gpio_irq_bank #(.WIDTH(PW)) bank_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin        (pin_i[b*PW +: PW]),
            .wr_unmask  (hit_bank_sel && dec_sel == SEL_UNMASK),
            .wr_maskset (hit_bank_sel && dec_sel == SEL_MASKSET),
            .wr_status  (hit_bank_sel && dec_sel == SEL_STATUS),
            .wr_trig    (hit_bank_sel && dec_sel == SEL_TRIG),
            .wr_pol     (hit_bank_sel && dec_sel == SEL_POL),
            .wr_both    (hit_bank_sel && dec_sel == SEL_BOTH),
            .wdata      (bus_wdata[PW-1:0]),
            .mask_q     (mask_a[b]),
            .stat_q     (stat_a[b]),
            .trig_q     (trig_a[b]),
            .pol_q      (pol_a[b]),
            .both_q     (both_a[b]),
            .hit        (hit_all[b*PW +: PW])
        );

        assign stat_all[b*PW +: PW] = stat_a[b];
        assign mask_all[b*PW +: PW] = mask_a[b];
    end

    // Return the addressed register, zero for write-only or unused words.
    always_comb begin
        bus_rdata = '0;
        case (dec_sel)
            SEL_MASK_RD: bus_rdata = DATA_W'(mask_a[dec_bank]);
            SEL_STATUS:  bus_rdata = DATA_W'(stat_a[dec_bank]);
            SEL_TRIG:    bus_rdata = DATA_W'(trig_a[dec_bank]);
            SEL_POL:     bus_rdata = DATA_W'(pol_a[dec_bank]);
            SEL_BOTH:    bus_rdata = DATA_W'(both_a[dec_bank]);
            default:     bus_rdata = '0;
        endcase
    end

    // Any unmasked pending pin across every bank.
    always_comb begin
        pend_any = |(stat_all & ~mask_all);
    end

    // Register the combined request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= pend_any;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/gpio_irq_unit_chk.sv
// Assertion checker for gpio_irq_unit, attached by bind.
// Decodes bank addresses on its own and watches status, mask and the
// detector outputs over time.
module gpio_irq_unit_chk #(
    parameter int NB     = 4,
    parameter int PW     = 32,
    parameter int AW     = 12,
    parameter int DW     = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic [AW-1:0]   bus_addr,
    input logic [DW-1:0]   bus_wdata,
    input logic            irq_o,
    input logic [NB*PW-1:0] stat_all,
    input logic [NB*PW-1:0] mask_all,
    input logic [NB*PW-1:0] hit_all
);

    for (genvar b = 0; b < NB; b++) begin : g_chk
        localparam logic [AW-1:0] A_UNMASK = AW'(12'h210 + 12'h040 * b);
        localparam logic [AW-1:0] A_MSET   = AW'(12'h214 + 12'h040 * b);
        localparam logic [AW-1:0] A_STAT   = AW'(12'h218 + 12'h040 * b);

        // R2: bits written 1 to mask-clear are unmasked next cycle.
        a_r2_unmask_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == A_UNMASK) |=>
            ((mask_all[b*PW +: PW] & $past(bus_wdata[PW-1:0])) == '0));

        // R3: bits written 1 to mask-set are masked next cycle.
        a_r3_maskset_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == A_MSET) |=>
            ((mask_all[b*PW +: PW] & $past(bus_wdata[PW-1:0])) ==
             $past(bus_wdata[PW-1:0])));

        // R7: cleared bits with no fresh detection are zero next cycle.
        a_r7_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == A_STAT) |=>
            ((stat_all[b*PW +: PW] &
              $past(bus_wdata[PW-1:0] & ~hit_all[b*PW +: PW])) == '0));
    end

    // R8: every detection shows in status on the next cycle.
    a_r8_detect_sets: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat_all & $past(hit_all)) == $past(hit_all)));

    // R9: the interrupt reflects last cycle's unmasked pending state.
    a_r9_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(stat_all & ~mask_all)));

endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(
    .NB (NUM_BANKS),
    .PW (PINS_PER_BANK),
    .AW (ADDR_W),
    .DW (DATA_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .stat_all  (stat_all),
    .mask_all  (mask_all),
    .hit_all   (hit_all)
);

// File: tb/gpio_irq_unit_tb_top.sv
// Bench for gpio_irq_unit: directed corners then seeded random traffic,
// all compared against a cycle model built from the requirements.
module gpio_irq_unit_tb_top;

    localparam int NB = 4;
    localparam int PW = 32;
    localparam int NP = NB * PW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   pin_i = '0;
    logic            bus_wr = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Model state.
    logic [PW-1:0] m_mask [NB];
    logic [PW-1:0] m_stat [NB];
    logic [PW-1:0] m_trig [NB];
    logic [PW-1:0] m_pol  [NB];
    logic [PW-1:0] m_both [NB];
    logic [PW-1:0] m_prev [NB];
    logic          m_irq;
    logic [NP-1:0] cur_p = '0;

    localparam logic [5:0] W_MASK = 6'h0C, W_UNM = 6'h10, W_MSET = 6'h14,
                           W_STAT = 6'h18, W_TRIG = 6'h1C, W_POL = 6'h20,
                           W_BOTH = 6'h24;

    gpio_irq_unit dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    always #10 clk = ~clk;

    function automatic logic [11:0] ra(input int b, input logic [5:0] w);
        return 12'h200 + 12'(b * 64) + {6'b0, w};
    endfunction

    function automatic bit dec(input logic [11:0] a, output int b, output logic [5:0] w);
        int hi;
        hi = int'(a[11:6]);
        w = a[5:0];
        b = hi - 8;
        return (hi >= 8) && (b < NB);
    endfunction

    function automatic logic [PW-1:0] f_hit(input logic [PW-1:0] p, pr, t, po, an);
        logic [PW-1:0] h;
        for (int i = 0; i < PW; i++) begin
            if (t[i]) begin
                if (an[i]) h[i] = p[i] ^ pr[i];
                else if (po[i]) h[i] = p[i] & ~pr[i];
                else h[i] = ~p[i] & pr[i];
            end else begin
                h[i] = po[i] ? p[i] : ~p[i];
            end
        end
        return h;
    endfunction

    function automatic logic [31:0] m_read(input logic [11:0] a);
        int b;
        logic [5:0] w;
        if (!dec(a, b, w)) return 32'h0;
        case (w)
            W_MASK: return m_mask[b];
            W_STAT: return m_stat[b];
            W_TRIG: return m_trig[b];
            W_POL:  return m_pol[b];
            W_BOTH: return m_both[b];
            default: return 32'h0;
        endcase
    endfunction

    // One clock: drive at the falling edge, update the model, pass the rising edge.
    task automatic tick(input logic [NP-1:0] p, input bit wr,
                        input logic [11:0] a, input logic [31:0] d);
        int wb;
        logic [5:0] ww;
        bit ok;
        logic [PW-1:0] h;
        @(negedge clk);
        pin_i = p; bus_wr = wr; bus_addr = a; bus_wdata = d;
        cur_p = p;
        ok = dec(a, wb, ww);
        m_irq = 1'b0;
        for (int b = 0; b < NB; b++) m_irq |= |(m_stat[b] & ~m_mask[b]);
        if (!rst_n) m_irq = 1'b0;
        for (int b = 0; b < NB; b++) begin
            if (!rst_n) begin
                m_mask[b] = '1; m_stat[b] = '0; m_trig[b] = '0;
                m_pol[b] = '0; m_both[b] = '0;
            end else begin
                h = f_hit(p[b*PW +: PW], m_prev[b], m_trig[b], m_pol[b], m_both[b]);
                if (wr && ok && wb == b && ww == W_STAT) m_stat[b] = m_stat[b] & ~d;
                m_stat[b] = m_stat[b] | h;
                if (wr && ok && wb == b) begin
                    case (ww)
                        W_UNM:  m_mask[b] = m_mask[b] & ~d;
                        W_MSET: m_mask[b] = m_mask[b] | d;
                        W_TRIG: m_trig[b] = d;
                        W_POL:  m_pol[b] = d;
                        W_BOTH: m_both[b] = d;
                        default: ;
                    endcase
                end
            end
            m_prev[b] = p[b*PW +: PW];
        end
        @(posedge clk);
        #2 bus_wr = 1'b0;
    endtask

    task automatic idle();
        tick(cur_p, 1'b0, 12'h0, 32'h0);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        tick(cur_p, 1'b1, a, d);
    endtask

    task automatic chk_rd(input logic [11:0] a, input string tag);
        logic [31:0] e;
        bus_addr = a;
        #1;
        e = m_read(a);
        n_chk++;
        if (bus_rdata !== e) begin
            n_fail++;
            $display("FAIL %s read addr=%h got=%h exp=%h", tag, a, bus_rdata, e);
        end
    endtask

    task automatic chk_irq(input string tag);
        n_chk++;
        if (irq_o !== m_irq) begin
            n_fail++;
            $display("FAIL %s irq got=%b exp=%b", tag, irq_o, m_irq);
        end
    endtask

    function automatic string tag_of(input logic [5:0] w);
        case (w)
            W_MASK: return "R2";
            W_STAT: return "R7";
            default: return "R10";
        endcase
    endfunction

    initial begin
        logic [5:0] words [7];
        logic [NP-1:0] p;
        words = '{W_MASK, W_UNM, W_MSET, W_STAT, W_TRIG, W_POL, W_BOTH};
        void'($urandom(32'h5EED1234));

        // R1: reset values seen while reset is held.
        for (int k = 0; k < 3; k++) idle();
        for (int b = 0; b < NB; b++)
            for (int k = 0; k < 7; k++) chk_rd(ra(b, words[k]), "R1");
        chk_irq("R1");

        // Leave reset: default level-low sees low pins.
        rst_n = 1'b1;
        idle();
        chk_rd(ra(0, W_STAT), "R4");

        // R4/R7: make bank0 level-high, clear, then hold a high level.
        wr(ra(0, W_POL), 32'hFFFF_FFFF);
        wr(ra(0, W_STAT), 32'hFFFF_FFFF);
        chk_rd(ra(0, W_STAT), "R7");
        p = cur_p; p[3] = 1'b1;
        tick(p, 1'b0, 12'h0, 32'h0);
        chk_rd(ra(0, W_STAT), "R4");
        wr(ra(0, W_STAT), 32'h0000_0008);
        chk_rd(ra(0, W_STAT), "R4");
        wr(ra(0, W_STAT), 32'h0);
        chk_rd(ra(0, W_STAT), "R7");

        // R2/R9: unmask one pin, interrupt follows a cycle later.
        wr(ra(0, W_UNM), 32'h0000_0008);
        chk_rd(ra(0, W_MASK), "R2");
        idle();
        chk_irq("R9");
        idle();
        chk_irq("R9");

        // R3: mask every pin of bank0.
        wr(ra(0, W_MSET), 32'hFFFF_FFFF);
        chk_rd(ra(0, W_MASK), "R3");
        idle();
        idle();
        chk_irq("R9");

        // R5: bank1 rising edges.
        wr(ra(1, W_TRIG), 32'hFFFF_FFFF);
        wr(ra(1, W_POL), 32'hFFFF_FFFF);
        wr(ra(1, W_STAT), 32'hFFFF_FFFF);
        chk_rd(ra(1, W_STAT), "R5");
        p = cur_p; p[PW + 0] = 1'b1;
        tick(p, 1'b0, 12'h0, 32'h0);
        chk_rd(ra(1, W_STAT), "R5");
        wr(ra(1, W_STAT), 32'hFFFF_FFFF);
        p = cur_p; p[PW + 0] = 1'b0;
        tick(p, 1'b0, 12'h0, 32'h0);
        chk_rd(ra(1, W_STAT), "R5");
        wr(ra(1, W_POL), 32'h0);
        p = cur_p; p[PW + 0] = 1'b1;
        tick(p, 1'b0, 12'h0, 32'h0);
        p = cur_p; p[PW + 0] = 1'b0;
        tick(p, 1'b0, 12'h0, 32'h0);
        chk_rd(ra(1, W_STAT), "R5");

        // R6: bank2 both edges with polarity 0.
        wr(ra(2, W_TRIG), 32'hFFFF_FFFF);
        wr(ra(2, W_BOTH), 32'hFFFF_FFFF);
        wr(ra(2, W_STAT), 32'hFFFF_FFFF);
        p = cur_p; p[2*PW + 5] = 1'b1;
        tick(p, 1'b0, 12'h0, 32'h0);
        chk_rd(ra(2, W_STAT), "R6");
        wr(ra(2, W_STAT), 32'hFFFF_FFFF);
        p = cur_p; p[2*PW + 5] = 1'b0;
        tick(p, 1'b0, 12'h0, 32'h0);
        chk_rd(ra(2, W_STAT), "R6");

        // R8: edge and clear in the same cycle.
        wr(ra(2, W_STAT), 32'hFFFF_FFFF);
        p = cur_p; p[2*PW + 9] = 1'b1;
        tick(p, 1'b1, ra(2, W_STAT), 32'hFFFF_FFFF);
        chk_rd(ra(2, W_STAT), "R8");

        // R10: unmapped addresses read 0 and ignore writes.
        chk_rd(12'h100, "R10");
        chk_rd(ra(NB, W_MASK), "R10");
        chk_rd(ra(0, W_UNM), "R10");
        wr(ra(0, 6'h00), 32'hFFFF_FFFF);
        wr(ra(NB, W_UNM), 32'hFFFF_FFFF);
        chk_rd(ra(0, W_MASK), "R10");

        // Seeded random traffic.
        for (int n = 0; n < 4000; n++) begin
            bit do_wr;
            logic [11:0] a;
            logic [31:0] d;
            p = cur_p;
            if ($urandom % 2 == 0) p = {$urandom, $urandom, $urandom, $urandom};
            do_wr = ($urandom % 3) == 0;
            a = ($urandom % 16 == 0) ? 12'($urandom) : ra(int'($urandom % NB), words[$urandom % 7]);
            d = ($urandom % 8 == 0) ? 32'hFFFF_FFFF : $urandom;
            tick(p, do_wr, a, d);
            begin
                logic [5:0] rw;
                rw = words[$urandom % 7];
                chk_rd(ra(int'($urandom % NB), rw), tag_of(rw));
            end
            chk_irq("R9");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule